// File: doc/BRIEF.md
# Ternary Ripple Adder/Subtractor

This block adds or subtracts two unsigned ternary numbers of a fixed number of digits. Each digit (trit) travels on two binary wires. The carry moves from one digit position to the next through a chain of adder cells. The lowest position is a half adder. Every higher position is a reduced full adder. A reduced full adder only decodes carry-in values 0 and 1, which is all a ripple chain of this kind can ever deliver.

Subtraction reuses the same chain. Each digit of the second operand is replaced by its ternary complement (two minus the digit). The lowest position then switches from the half adder to a reduced full adder with a constant carry-in of one. The digit result and the carry leaving the top position are captured in an output register, so both appear one clock after the operands are presented.

Top module: `tern_addsub`

## Requirements
- R1: Digits use the code 00 for 0, 01 for 1 and 10 for 2. Code 11 is illegal on the inputs, and the outputs only ever carry legal codes.
- R2: With `sub_mode` low, the registered `res_trits` equals (A+B) mod 3^N, and `carry_out` is 1 exactly when A+B ≥ 3^N. Both are valid on the clock edge after the operands are sampled.
- R3: With `sub_mode` high, `res_trits` equals (A−B) mod 3^N, and `carry_out` is 1 exactly when A ≥ B.
- R4: No carry inside the chain ever takes the value 2, and every full-adder cell sees a carry-in of only 0 or 1.
- R5: In add mode, the lowest position turns 2+2 into sum digit 1 with carry 1, so A=2 and B=2 give a result of 4 with `carry_out` 0.
- R6: Adding zero returns A with `carry_out` 0. Subtracting zero returns A with `carry_out` 1.
- R7: While `rst_n` is low, `res_trits` is all 00 codes and `carry_out` is 0.
- R8: With every digit of both operands at 2, add mode yields 3^N−2 with `carry_out` 1, and subtract mode yields 0 with `carry_out` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| sub_mode | input | 1 | 0 selects A+B, 1 selects A−B |
| a_trits | input | 2*N_TRITS | Operand A, two bits per digit, digit 0 in bits 1:0 |
| b_trits | input | 2*N_TRITS | Operand B, same packing as A |
| res_trits | output | 2*N_TRITS | Registered result digits, same packing |
| carry_out | output | 1 | Registered carry from the top digit position |

## Verification
The assertions assume that every input digit holds one of the three legal codes. They treat code 11 as a violation, because the chain arithmetic is only defined for legal digits. They also assume that the operands meet `rst_n` high on the clock edge they are meant for. The stimulus builds every operand by converting an integer below 3^N into base-3 digits, so code 11 never reaches the inputs. It changes the operands only on the falling clock edge.

// File: rtl/tern_pkg.sv
package tern_pkg;

    // Two-bit digit code: 00 -> 0, 01 -> 1, 10 -> 2, 11 illegal
    typedef logic [1:0] trit_t;

    localparam trit_t TRIT_ZERO = 2'b00;
    localparam trit_t TRIT_ONE  = 2'b01;
    localparam trit_t TRIT_TWO  = 2'b10;
    localparam trit_t TRIT_BAD  = 2'b11;

    function automatic logic trit_legal(input trit_t t);
        return t != TRIT_BAD;
    endfunction

endpackage

// File: rtl/tern_digit_inv.sv
module tern_digit_inv
    import tern_pkg::*;
(
    input  trit_t d_i,
    output trit_t inv_o
);

    // Ternary complement: two minus the digit
    always_comb begin
        unique case (d_i)
            TRIT_ZERO: inv_o = TRIT_TWO;
            TRIT_ONE:  inv_o = TRIT_ONE;
            TRIT_TWO:  inv_o = TRIT_ZERO;
            default:   inv_o = TRIT_BAD;
        endcase
    end

endmodule

// File: rtl/tern_half_add.sv
module tern_half_add
    import tern_pkg::*;
(
    input  trit_t x_i,
    input  trit_t y_i,
    output trit_t sum_o,
    output trit_t cy_o
);

    logic [2:0] total;

    always_comb begin
        total = {1'b0, x_i} + {1'b0, y_i};
        if (total >= 3'd3) begin
            sum_o = 2'(total - 3'd3);
            cy_o  = TRIT_ONE;
        end else begin
            sum_o = total[1:0];
            cy_o  = TRIT_ZERO;
        end
    end

endmodule

// File: rtl/tern_part_fa.sv
module tern_part_fa
    import tern_pkg::*;
(
    input  trit_t x_i,
    input  trit_t y_i,
    input  trit_t cin_i,
    output trit_t sum_o,
    output trit_t cy_o
);

    logic [2:0] total;

    // Reduced cell: only the low bit of the carry code is decoded,
    // so carry-in 2 has no rows of its own.
    always_comb begin
        total = {1'b0, x_i} + {1'b0, y_i} + {2'b00, cin_i[0]};
        if (total >= 3'd3) begin
            sum_o = 2'(total - 3'd3);
            cy_o  = TRIT_ONE;
        end else begin
            sum_o = total[1:0];
            cy_o  = TRIT_ZERO;
        end
    end

endmodule

// File: rtl/tern_addsub.sv
module tern_addsub
    import tern_pkg::*;
#(
    parameter int unsigned N_TRITS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sub_mode,
    input  logic [2*N_TRITS-1:0]   a_trits,
    input  logic [2*N_TRITS-1:0]   b_trits,
    output logic [2*N_TRITS-1:0]   res_trits,
    output logic                   carry_out
);

    localparam int unsigned W = 2 * N_TRITS;

    typedef struct packed {
        logic [W-1:0] res;
        logic         cy;
    } out_t;

    trit_t        b_eff   [N_TRITS];
    trit_t        sum_w   [N_TRITS];
    trit_t        chain   [N_TRITS+1];
    logic [W-1:0] sum_flat;
    out_t         st_d, st_q;

    assign chain[0] = TRIT_ZERO;

    for (genvar i = 0; i < N_TRITS; i++) begin : g_pos
        trit_t b_inv;

        tern_digit_inv u_inv (
            .d_i   (b_trits[2*i +: 2]),
            .inv_o (b_inv)
        );

        assign b_eff[i] = sub_mode ? b_inv : b_trits[2*i +: 2];

        if (i == 0) begin : g_lsb
            trit_t ha_s, ha_c, fa_s, fa_c;

            tern_half_add u_ha (
                .x_i   (a_trits[1:0]),
                .y_i   (b_eff[0]),
                .sum_o (ha_s),
                .cy_o  (ha_c)
            );

            tern_part_fa u_fa (
                .x_i   (a_trits[1:0]),
                .y_i   (b_eff[0]),
                .cin_i (TRIT_ONE),
                .sum_o (fa_s),
                .cy_o  (fa_c)
            );

            assign sum_w[0] = sub_mode ? fa_s : ha_s;
            assign chain[1] = sub_mode ? fa_c : ha_c;
        end else begin : g_upper
            tern_part_fa u_fa (
                .x_i   (a_trits[2*i +: 2]),
                .y_i   (b_eff[i]),
                .cin_i (chain[i]),
                .sum_o (sum_w[i]),
                .cy_o  (chain[i+1])
            );

            // R4: the carry entering this cell is 0 or 1
            p_cin_small_r4: assert property (@(posedge clk) disable iff (!rst_n)
                chain[i] == TRIT_ZERO || chain[i] == TRIT_ONE);
        end

        assign sum_flat[2*i +: 2] = sum_w[i];

        // R1: input digits must be legal codes
        p_legal_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
            trit_legal(a_trits[2*i +: 2]));
        p_legal_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
            trit_legal(b_trits[2*i +: 2]));
        // R1: registered result digits are legal codes
        p_legal_res_r1: assert property (@(posedge clk) disable iff (!rst_n)
            trit_legal(res_trits[2*i +: 2]));
    end

    // R4: the carry out of the top position is 0 or 1
    p_top_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chain[N_TRITS] != TRIT_TWO && chain[N_TRITS] != TRIT_BAD);

    always_comb begin
        st_d     = st_q;
        st_d.res = sum_flat;
        st_d.cy  = chain[N_TRITS][0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_trits = st_q.res;
    assign carry_out = st_q.cy;

    // R6: adding zero returns A with no carry
    p_add_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sub_mode && b_trits == '0) |=> (res_trits == $past(a_trits) && !carry_out));
    // R6: subtracting zero returns A with carry set
    p_sub_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_mode && b_trits == '0) |=> (res_trits == $past(a_trits) && carry_out));
    // R3: subtracting an operand from itself gives zero with carry set
    p_sub_self_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_mode && a_trits == b_trits) |=> (res_trits == '0 && carry_out));

endmodule

// File: tb/tb_tern_addsub.sv
`timescale 1ns/1ps
module tb_tern_addsub;

    localparam int N   = 4;
    localparam int W   = 2 * N;
    localparam int MOD = 81;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sub_mode = 1'b0;
    logic [W-1:0] a_trits = '0;
    logic [W-1:0] b_trits = '0;
    logic [W-1:0] res_trits;
    logic         carry_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tern_addsub #(.N_TRITS(N)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sub_mode  (sub_mode),
        .a_trits   (a_trits),
        .b_trits   (b_trits),
        .res_trits (res_trits),
        .carry_out (carry_out)
    );

    function automatic logic [W-1:0] enc(input int v);
        logic [W-1:0] r = '0;
        int x = v;
        for (int i = 0; i < N; i++) begin
            r[2*i +: 2] = 2'(x % 3);
            x = x / 3;
        end
        return r;
    endfunction

    function automatic int dec(input logic [W-1:0] t);
        int v = 0;
        for (int i = N - 1; i >= 0; i--) v = v * 3 + int'(t[2*i +: 2]);
        return v;
    endfunction

    function automatic bit all_legal(input logic [W-1:0] t);
        for (int i = 0; i < N; i++) if (t[2*i +: 2] == 2'b11) return 1'b0;
        return 1'b1;
    endfunction

    task automatic apply(input bit sm, input int a, input int b);
        @(negedge clk);
        sub_mode = sm;
        a_trits  = enc(a);
        b_trits  = enc(b);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int exp_v, input bit exp_c);
        checks++;
        if (!all_legal(res_trits) || dec(res_trits) != exp_v || carry_out !== exp_c) begin
            errors++;
            $display("FAIL %s: got value %0d carry %0b (raw %b), expected %0d carry %0b",
                     req, dec(res_trits), carry_out, res_trits, exp_v, exp_c);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        sub_mode = 1'b1;
        a_trits = enc(40);
        b_trits = enc(7);
        repeat (3) @(negedge clk);
        check("R7", 0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_half_two_two;
        apply(1'b0, 2, 2);
        check("R5", 4, 1'b0);
    endtask

    task automatic t_zero_operand;
        apply(1'b0, 53, 0);
        check("R6 add", 53, 1'b0);
        apply(1'b1, 53, 0);
        check("R6 sub", 53, 1'b1);
    endtask

    task automatic t_all_twos;
        apply(1'b0, MOD - 1, MOD - 1);
        check("R8 add", MOD - 2, 1'b1);
        apply(1'b1, MOD - 1, MOD - 1);
        check("R8 sub", 0, 1'b1);
    endtask

    task automatic t_borrow_edges;
        apply(1'b1, 0, 1);
        check("R3 borrow", MOD - 1, 1'b0);
        apply(1'b1, 1, 0);
        check("R3 no borrow", 1, 1'b1);
        apply(1'b0, 40, 41);
        check("R2 wrap", 0, 1'b1);
        apply(1'b0, 40, 40);
        check("R2 below", 80, 1'b0);
    endtask

    task automatic t_exhaustive;
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < MOD; a++) begin
                for (int b = 0; b < MOD; b++) begin
                    apply(m[0], a, b);
                    if (m == 0) check("R2", (a + b) % MOD, (a + b) >= MOD);
                    else check("R3", (a - b + MOD) % MOD, a >= b);
                end
            end
        end
    endtask

    task automatic t_random;
        for (int k = 0; k < 200; k++) begin
            int a = int'($urandom_range(MOD - 1));
            int b = int'($urandom_range(MOD - 1));
            bit m = 1'($urandom_range(1));
            apply(m, a, b);
            if (!m) check("R2 R4 random", (a + b) % MOD, (a + b) >= MOD);
            else check("R3 R4 random", (a - b + MOD) % MOD, a >= b);
        end
    endtask

    task automatic t_reset_mid;
        apply(1'b0, 80, 80);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 mid-run", 0, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_half_two_two();
        t_zero_operand();
        t_all_twos();
        t_borrow_edges();
        t_exhaustive();
        t_random();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule